// File: doc/BRIEF.md
# Indexed CMOS Register File

This block is a 256-byte store of configuration and clock bytes that a host reaches through two byte-wide ports on a simple synchronous bus. The host first writes a register number to the index port. It then reads or writes the byte at that number through the data port. The index stays put across any number of data accesses, so the host can poll one location repeatedly without writing the index again.

Every location carries a valid bit that is set the first time the location is written. A read of a location that has never been written does not return data. It returns zero and raises an error flag, so firmware can tell a missing setting from a stored zero.

One location, the clock status byte at index 0x0A, has a read side effect. Each successful read of it inverts its bit 7, so a polling loop sees the update-in-progress flag alternate. A separate preload port lets the integration logic seed bytes after reset, such as memory size, boot order and the initial time. The counters and interrupt logic that share this storage are not part of this block.

Top module: `cmos_regfile`

## Requirements
- R1: A host write with `host_sel`=0 (index port) loads the low 8 bits of `host_wdata` as the current index. It changes no stored byte and no valid bit, and the index holds until the next index write or reset.
- R2: A host write with `host_sel`=1 (data port) stores `host_wdata` at the current index and marks that location valid. A stored value of 0x00 counts as valid data.
- R3: A host read with `host_sel`=1 of a valid location presents the stored byte on `host_rdata`, with `host_err`=0, from the clock edge that samples the read strobe.
- R4: A data read of a location that has never been written since reset gives `host_rdata`=0x00 and `host_err`=1. It leaves the location invalid.
- R5: A host read with `host_sel`=0 (index port) returns 0xFF with `host_err`=0.
- R6: A successful data read of index 0x0A returns the byte as it was before the read, then inverts bit 7 of the stored byte. A failed read of 0x0A does not change it. If a preload write to 0x0A occurs in the same cycle, the preload value is stored and no inversion happens.
- R7: While `rst` is high, all valid bits are cleared, the index returns to 0 and `posted` goes low. After reset the outputs read `host_rdata`=0x00 and `host_err`=0.
- R8: A preload write (`pre_we`=1) stores `pre_data` at `pre_addr` and marks it valid. In a cycle with a preload write, a host data-port write is dropped.
- R9: `posted` is 0 after reset, goes to 1 on the first index-port write, and stays 1 until the next reset.
- R10: `host_rdata` and `host_err` change only at a read. Idle cycles, host writes and preload writes leave them unchanged, even when they write the location last read.
- R11: If `host_wr` and `host_rd` are both high, the write is performed and the read is ignored.
- R12: Valid bits are kept per location. Writing one index does not validate its neighbours at index ±1, whether or not they share a byte of the map.
- R13: A data read, successful or not, does not change any other stored byte or the index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Port select: 0 index port, 1 data port |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read result, valid one edge after the read strobe |
| host_err | output | 1 | Read of a never-written location |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 8 | Preload location |
| pre_data | input | 8 | Preload byte |
| posted | output | 1 | An index has been written since reset |

## Verification
Some properties are checked by assertions on every cycle:
- The index-port read value.
- A raised error flag always comes with zero data.
- The outputs do not move between reads.
- `posted` stays high once set, and the index holds across data-port writes.
- The valid map never loses a bit outside reset.
- The status bit inverts after an accepted read.

Other behaviour can only be shown by the bench's scenarios:
- The byte a read returns, including the value before the toggle.
- Which locations stay invalid after writes to their neighbours.
- Preload priority over host writes, and the toggle dropped when a preload hits 0x0A.
- A write and a read strobed together.
- A reset in the middle of a run.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

  // Host port select encoding
  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } port_e;

  // Access state of the index latch
  typedef enum logic {
    ST_READY  = 1'b0,
    ST_POSTED = 1'b1
  } idx_state_e;

  // Kind of result held on the read outputs
  typedef enum logic [2:0] {
    RES_NONE  = 3'd0,
    RES_INDEX = 3'd1,
    RES_MISS  = 3'd2,
    RES_RAM   = 3'd3,
    RES_HOT   = 3'd4
  } rd_res_e;

endpackage

// File: rtl/cmos_byte_ram.sv
module cmos_byte_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first simple dual-port memory, no reset, suited to block RAM.
  // Output holds when re is low.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/cmos_valid_map.sv
module cmos_valid_map #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic [AW-1:0] look_addr,
  output logic          hit
);

  localparam int DEPTH = 1 << AW;
  localparam int ROWS  = DEPTH / 8;
  localparam int RW    = AW - 3;

  // One bit per location, grouped eight to a row:
  // row = addr / 8, bit = addr % 8
  logic [ROWS-1:0][7:0] map_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else if (set_en) begin
      map_q[set_addr[AW-1:3]][set_addr[2:0]] <= 1'b1;
    end
  end

  logic [RW-1:0] look_row;
  assign look_row = look_addr[AW-1:3];
  assign hit      = map_q[look_row][look_addr[2:0]];

  AST_MAP_NEVER_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(map_q) >= $countones($past(map_q)))); // R2

endmodule

// File: rtl/cmos_hot_byte.sv
module cmos_hot_byte #(
  parameter int DW      = 8,
  parameter int FLIP_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          toggle_en,
  output logic [DW-1:0] byte_q
);

  localparam logic [DW-1:0] FLIP_MASK = DW'(1) << FLIP_BIT;

  // A write wins over the read-side inversion in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_q <= '0;
    end else if (wr_en) begin
      byte_q <= wr_data;
    end else if (toggle_en) begin
      byte_q <= byte_q ^ FLIP_MASK;
    end
  end

  AST_HOT_BIT_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (toggle_en && !wr_en) |=> (byte_q[FLIP_BIT] != $past(byte_q[FLIP_BIT]))); // R6

  AST_HOT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (byte_q == $past(wr_data))); // R6

endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
  import cmos_pkg::*;
#(
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [ADDR_W-1:0] HOT_IDX  = 8'h0A,
  parameter int               HOT_BIT  = 7,
  parameter logic [DATA_W-1:0] IDX_RVAL = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_err,
  input  logic              pre_we,
  input  logic [ADDR_W-1:0] pre_addr,
  input  logic [DATA_W-1:0] pre_data,
  output logic              posted
);

  // ---------------- host decode ----------------
  logic sel_data, sel_index;
  logic idx_wr, data_wr, rd_fire, rd_data, rd_index;

  assign sel_data  = (host_sel == 1'(PORT_DATA));
  assign sel_index = (host_sel == 1'(PORT_INDEX));
  assign idx_wr    = host_wr && sel_index;
  assign data_wr   = host_wr && sel_data && !pre_we;
  assign rd_fire   = host_rd && !host_wr;
  assign rd_data   = rd_fire && sel_data;
  assign rd_index  = rd_fire && sel_index;

  // ---------------- index latch ----------------
  logic [ADDR_W-1:0] idx_q;
  idx_state_e        st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      st_q  <= ST_READY;
    end else if (idx_wr) begin
      idx_q <= host_wdata[ADDR_W-1:0];
      st_q  <= ST_POSTED;
    end
  end

  assign posted = (st_q == ST_POSTED);

  // ---------------- shared write port ----------------
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  assign wr_en   = pre_we || data_wr;
  assign wr_addr = pre_we ? pre_addr : idx_q;
  assign wr_data = pre_we ? pre_data : host_wdata;

  // ---------------- storage ----------------
  logic [DATA_W-1:0] ram_q;
  logic              hit;
  logic [DATA_W-1:0] hot_byte;
  logic              is_hot, hot_wr, toggle_en;

  cmos_byte_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .re    (rd_data),
    .raddr (idx_q),
    .rdata (ram_q)
  );

  cmos_valid_map #(.AW(ADDR_W)) u_vmap (
    .clk       (clk),
    .rst       (rst),
    .set_en    (wr_en),
    .set_addr  (wr_addr),
    .look_addr (idx_q),
    .hit       (hit)
  );

  assign is_hot    = (idx_q == HOT_IDX);
  assign hot_wr    = wr_en && (wr_addr == HOT_IDX);
  assign toggle_en = rd_data && hit && is_hot;

  cmos_hot_byte #(.DW(DATA_W), .FLIP_BIT(HOT_BIT)) u_hot (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (hot_wr),
    .wr_data   (wr_data),
    .toggle_en (toggle_en),
    .byte_q    (hot_byte)
  );

  // ---------------- read result capture ----------------
  rd_res_e           res_q;
  logic [DATA_W-1:0] hot_cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q     <= RES_NONE;
      hot_cap_q <= '0;
    end else if (rd_index) begin
      res_q <= RES_INDEX;
    end else if (rd_data) begin
      if (!hit)        res_q <= RES_MISS;
      else if (is_hot) res_q <= RES_HOT;
      else             res_q <= RES_RAM;
      hot_cap_q <= hot_byte;
    end
  end

  always_comb begin
    unique case (res_q)
      RES_INDEX: host_rdata = IDX_RVAL;
      RES_RAM:   host_rdata = ram_q;
      RES_HOT:   host_rdata = hot_cap_q;
      default:   host_rdata = '0;
    endcase
  end

  assign host_err = (res_q == RES_MISS);

  // ---------------- assertions ----------------
  AST_INDEX_PORT_READ: assert property (@(posedge clk) disable iff (rst)
    rd_index |=> (host_rdata == IDX_RVAL && !host_err)); // R5

  AST_MISS_GIVES_ZERO: assert property (@(posedge clk) disable iff (rst)
    host_err |-> (host_rdata == '0)); // R4

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> ($stable(host_rdata) && $stable(host_err))); // R10

  AST_POSTED_STICKY: assert property (@(posedge clk) disable iff (rst)
    posted |=> posted); // R9

  AST_INDEX_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !idx_wr |=> $stable(idx_q)); // R1

endmodule

// File: tb/sim_cmos_regfile.sv
module sim_cmos_regfile;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       host_err;
  logic       pre_we = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;
  logic       posted;

  int nchk = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  cmos_regfile u0 (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_err(host_err), .pre_we(pre_we), .pre_addr(pre_addr),
    .pre_data(pre_data), .posted(posted)
  );

  // One bus cycle: drive at a falling edge, sampled by the next rising edge,
  // then released; the caller continues at the following falling edge.
  task automatic step(input logic sel, input logic wr, input logic rd,
                      input logic [7:0] d, input logic pwe,
                      input logic [7:0] pa, input logic [7:0] pd);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = d;
    pre_we = pwe; pre_addr = pa; pre_data = pd;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    pre_we = 1'b0; pre_addr = '0; pre_data = '0;
  endtask

  task automatic set_idx(input logic [7:0] i); step(1'b0, 1'b1, 1'b0, i, 1'b0, 8'h00, 8'h00); endtask
  task automatic put(input logic [7:0] d);     step(1'b1, 1'b1, 1'b0, d, 1'b0, 8'h00, 8'h00); endtask
  task automatic get();                        step(1'b1, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h00); endtask
  task automatic preload(input logic [7:0] a, input logic [7:0] d); step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1, a, d); endtask

  task automatic chk(input string req, input logic [7:0] exp_d, input logic exp_e);
    nchk++;
    if (host_rdata !== exp_d || host_err !== exp_e) begin
      nerr++;
      $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
               req, host_rdata, host_err, exp_d, exp_e);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp_v);
    nchk++;
    if (act !== exp_v) begin
      nerr++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp_v);
    end
  endtask

  // Vector: {rd, sel, data, exp_data, exp_err, req}
  localparam int NV = 16;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h20, 8'h00, 1'b0, 4'd1},   // index 0x20       R1
    {1'b0, 1'b1, 8'h5A, 8'h00, 1'b0, 4'd2},   // store 0x5A       R2
    {1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, 4'd3},   // read back        R3
    {1'b0, 1'b0, 8'h21, 8'h00, 1'b0, 4'd1},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 4'd4},   // unwritten 0x21   R4
    {1'b1, 1'b0, 8'h00, 8'hFF, 1'b0, 4'd5},   // index port read  R5
    {1'b0, 1'b0, 8'hFF, 8'h00, 1'b0, 4'd1},
    {1'b0, 1'b1, 8'hC3, 8'h00, 1'b0, 4'd2},
    {1'b1, 1'b1, 8'h00, 8'hC3, 1'b0, 4'd3},   // top location     R3
    {1'b0, 1'b0, 8'h20, 8'h00, 1'b0, 4'd1},
    {1'b1, 1'b1, 8'h00, 8'h5A, 1'b0, 4'd13},  // 0x20 untouched   R13
    {1'b0, 1'b0, 8'h1F, 8'h00, 1'b0, 4'd1},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 4'd12},  // neighbour row    R12
    {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 4'd1},
    {1'b0, 1'b1, 8'h00, 8'h00, 1'b0, 4'd2},
    {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 4'd2}    // stored zero valid R2
  };

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R7 reset outputs", 8'h00, 1'b0);
    chk_bit("R9 posted after reset", posted, 1'b0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic       v_rd  = VEC[i][22];
      logic       v_sel = VEC[i][21];
      logic [7:0] v_d   = VEC[i][20:13];
      if (v_rd) begin
        step(v_sel, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, 8'h00);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][12:5], VEC[i][4]);
      end else begin
        step(v_sel, 1'b1, 1'b0, v_d, 1'b0, 8'h00, 8'h00);
      end
      if (i == 0) chk_bit("R9 posted after first index write", posted, 1'b1);
    end

    // R12: neighbours inside the same map row
    set_idx(8'h08); put(8'h77);
    set_idx(8'h09); get(); chk("R12 next in row", 8'h00, 1'b1);
    set_idx(8'h07); get(); chk("R12 previous row", 8'h00, 1'b1);
    set_idx(8'h08); get(); chk("R12 written one", 8'h77, 1'b0);

    // R10: outputs hold across idle cycles and writes to the last read location
    put(8'h99); preload(8'h08, 8'h44);
    repeat (2) @(negedge clk);
    chk("R10 hold after writes", 8'h77, 1'b0);
    get(); chk("R10 new read shows preload", 8'h44, 1'b0);

    // R11: write and read strobed together
    step(1'b1, 1'b1, 1'b1, 8'h3C, 1'b0, 8'h00, 8'h00);
    chk("R11 read ignored", 8'h44, 1'b0);
    get(); chk("R11 write done", 8'h3C, 1'b0);

    // R6: status byte inversion
    set_idx(8'h0A);
    get(); chk("R6 unwritten status", 8'h00, 1'b1);
    get(); chk("R6 failed read no toggle", 8'h00, 1'b1);
    put(8'h26);
    get(); chk("R6 first read", 8'h26, 1'b0);
    get(); chk("R6 second read", 8'hA6, 1'b0);
    get(); chk("R6 third read", 8'h26, 1'b0);
    // preload to the status byte in the same cycle as a read
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b1, 8'h0A, 8'h06);
    chk("R6 read during preload", 8'hA6, 1'b0);
    get(); chk("R6 preload beats toggle", 8'h06, 1'b0);
    get(); chk("R6 toggle after preload", 8'h86, 1'b0);

    // R8: preload stores and sets valid; host data write dropped
    preload(8'h50, 8'hE1);
    set_idx(8'h50); get(); chk("R8 preload valid", 8'hE1, 1'b0);
    set_idx(8'h40);
    step(1'b1, 1'b1, 1'b0, 8'h11, 1'b1, 8'h40, 8'h99);
    get(); chk("R8 same address priority", 8'h99, 1'b0);
    step(1'b1, 1'b1, 1'b0, 8'h55, 1'b1, 8'h41, 8'h22);
    get(); chk("R8 host write dropped", 8'h99, 1'b0);
    set_idx(8'h41); get(); chk("R8 other address stored", 8'h22, 1'b0);

    // R7: reset in the middle of a run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R7 outputs after reset", 8'h00, 1'b0);
    chk_bit("R7 posted cleared", posted, 1'b0);
    get(); chk("R7 index back to 0 and invalid", 8'h00, 1'b1);
    set_idx(8'h20); get(); chk("R7 valid bit cleared", 8'h00, 1'b1);
    set_idx(8'h0A); get(); chk("R7 status invalid", 8'h00, 1'b1);

    summary();
    $finish;
  end

endmodule